// File: doc/BRIEF.md
# GMII Transmit Elastic Buffer

This block carries the transmit side of a GMII link (an 8-bit data byte plus the enable and error qualifiers) from the clock of a remote MAC into the local core clock. The two clocks come from separate oscillators and may differ slightly in frequency. The crossing uses a small asynchronous FIFO. Its entries are flip-flops with a combinational read path.

The FIFO does not let its fill level wander until it hits full or empty. It keeps the level inside a band around a fixed target. When the writer is ahead, the write side discards idle words. When the reader is ahead, the read side stalls its pointer and emits a synthetic idle. Both adjustments happen only in the gaps between frames, so every byte of a frame, and its framing, leaves the block exactly as it arrived. Two sticky flags report the case where the adjustment could not keep up. Each clock domain has its own synchronous reset.

Top module: `gmii_tx_elastic`

## Requirements
- R1: Every word with the enable bit set leaves the core-clock side with its data byte and error bit unchanged, in the order it was written.
- R2: A word is idle when enable and error are both 0. Any word with enable or error set is always stored while the FIFO is not full, including words with error set and enable clear.
- R3: An idle word arriving while the write-side occupancy is above 18 entries is discarded and does not advance the write pointer.
- R4: When the read-side occupancy is below 14 and the last word driven out was idle, the read pointer holds and the output word is data 0x00, enable 0, error 0.
- R5: Idles are added or removed only between frames, so each frame leaves the block as one unbroken run of enable-high words with its original length.
- R6: After a read-side reset, the output stays idle until the read-side occupancy first reaches 16 entries.
- R7: The overflow flag goes high when a word that must be stored (not idle) arrives while all 32 entries are occupied. That word is lost. The flag stays high until the write-side reset.
- R8: The underflow flag goes high when the read side is running and finds the FIFO empty, and an idle is driven out in that cycle. The flag stays high until the read-side reset.
- R9: While reset is held, the outputs are data 0x00, enable 0 and error 0, and both flags are 0.
- R10: Pointers cross between the domains as Gray code through two-stage synchronizers, so each registered crossing pointer changes by at most one bit per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Transmit clock of the remote MAC |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| gtx_data_i | input | 8 | Transmit data byte from the MAC |
| gtx_en_i | input | 1 | Transmit enable from the MAC |
| gtx_er_i | input | 1 | Transmit error from the MAC |
| rd_clk | input | 1 | Core main clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| core_data_o | output | 8 | Data byte in the core clock domain |
| core_en_o | output | 1 | Enable in the core clock domain |
| core_er_o | output | 1 | Error in the core clock domain |
| overflow_o | output | 1 | Sticky overflow flag, write domain |
| underflow_o | output | 1 | Sticky underflow flag, read domain |

## Verification
The bound checker watches, on every cycle, the single-bit steps of both Gray pointers, the frozen write pointer on a discarded idle, the guaranteed write of every non-idle word while room remains, the all-zero word after each inserted idle, the idle output during priming, and the stickiness and reset clearing of both flags. Byte-exact frame integrity, and the absence of gaps inside frames while the two clocks drift against each other, can only be shown by the bench. It stretches one clock or the other during frames and compares whole frames at the output. The same holds for showing that discarding and inserting actually keep the FIFO off full and empty during long stalls of either clock.

// File: rtl/geb_pkg.sv
package geb_pkg;

    // One GMII transmit word as it travels through the buffer.
    typedef struct packed {
        logic [7:0] data;
        logic       en;
        logic       er;
    } gword_t;

    localparam gword_t GW_IDLE = '{data: 8'h00, en: 1'b0, er: 1'b0};

    // Read side either waits for the target fill or streams words.
    typedef enum logic {
        RD_PRIME = 1'b0,
        RD_RUN   = 1'b1
    } rd_mode_e;

    // A word may be added or removed only when it carries neither qualifier.
    function automatic logic gw_is_idle(input gword_t w);
        return !w.en && !w.er;
    endfunction

endpackage

// File: rtl/geb_ptr_sync.sv
// Two-stage synchronizer for a Gray-coded pointer, followed by the
// conversion back to binary in the receiving domain.
module geb_ptr_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= gray_i;
            stage2_q <= stage1_q;
        end
    end

    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            acc      = acc ^ stage2_q[i];
            bin_o[i] = acc;
        end
    end

endmodule

// File: rtl/geb_store.sv
// Flip-flop storage: written on the write clock, read combinationally.
module geb_store
    import geb_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  gword_t        wdata,
    input  logic [AW-1:0] raddr,
    output gword_t        rdata
);

    localparam int ENTRIES = 1 << AW;

    gword_t mem [ENTRIES];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/geb_wr_ctl.sv
// Write-domain control: occupancy, idle deletion, overflow.
module geb_wr_ctl #(
    parameter int AW        = 5,
    parameter int DEL_ABOVE = 18
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_idle_i,
    input  logic [AW:0] rsync_bin_i,
    output logic        we_o,
    output logic [AW-1:0] waddr_o,
    output logic [AW:0] wgray_o,
    output logic        full_o,
    output logic        drop_o,
    output logic        overflow_o
);

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] wbin_q;
    logic [PW-1:0] wbin_d;
    logic [PW-1:0] occ;
    logic          push;

    assign occ    = wbin_q - rsync_bin_i;
    assign full_o = (occ == PW'(DEPTH));
    assign drop_o = in_idle_i && (occ > PW'(DEL_ABOVE));
    assign push   = !full_o && !drop_o;
    assign wbin_d = wbin_q + PW'(push);

    assign we_o    = push;
    assign waddr_o = wbin_q[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin_q     <= '0;
            wgray_o    <= '0;
            overflow_o <= 1'b0;
        end else begin
            wbin_q  <= wbin_d;
            wgray_o <= wbin_d ^ (wbin_d >> 1);
            if (full_o && !drop_o) begin
                overflow_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/geb_rd_ctl.sv
// Read-domain control: priming, idle insertion, underflow, output register.
module geb_rd_ctl
    import geb_pkg::*;
#(
    parameter int AW         = 5,
    parameter int START_AT   = 16,
    parameter int INS_BELOW  = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW:0]   wsync_bin_i,
    input  gword_t        rdata_i,
    output logic [AW-1:0] raddr_o,
    output logic [AW:0]   rgray_o,
    output gword_t        word_o,
    output logic          underflow_o,
    output logic          priming_o,
    output logic          insert_o
);

    localparam int PW = AW + 1;

    rd_mode_e      mode_q;
    rd_mode_e      mode_d;
    logic [PW-1:0] rbin_q;
    logic [PW-1:0] rbin_d;
    logic [PW-1:0] occ;
    logic          empty;
    logic          take;
    gword_t        word_d;

    assign occ   = wsync_bin_i - rbin_q;
    assign empty = (occ == '0);

    always_comb begin
        mode_d   = mode_q;
        take     = 1'b0;
        insert_o = 1'b0;
        case (mode_q)
            RD_PRIME: begin
                if (occ >= PW'(START_AT)) begin
                    mode_d = RD_RUN;
                end
            end
            RD_RUN: begin
                if (!empty) begin
                    if (gw_is_idle(word_o) && (occ < PW'(INS_BELOW))) begin
                        insert_o = 1'b1;
                    end else begin
                        take = 1'b1;
                    end
                end
            end
            default: mode_d = RD_PRIME;
        endcase
    end

    assign word_d    = take ? rdata_i : GW_IDLE;
    assign rbin_d    = rbin_q + PW'(take);
    assign raddr_o   = rbin_q[AW-1:0];
    assign priming_o = (mode_q == RD_PRIME);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= RD_PRIME;
            rbin_q      <= '0;
            rgray_o     <= '0;
            word_o      <= GW_IDLE;
            underflow_o <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            rbin_q  <= rbin_d;
            rgray_o <= rbin_d ^ (rbin_d >> 1);
            word_o  <= word_d;
            if ((mode_q == RD_RUN) && empty) begin
                underflow_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/gmii_tx_elastic.sv
module gmii_tx_elastic
    import geb_pkg::*;
#(
    parameter int ADDR_W       = 5,
    parameter int TARGET_FILL  = 16,
    parameter int DELETE_ABOVE = 18,
    parameter int INSERT_BELOW = 14
) (
    input  logic       wr_clk,
    input  logic       wr_rst,
    input  logic [7:0] gtx_data_i,
    input  logic       gtx_en_i,
    input  logic       gtx_er_i,
    input  logic       rd_clk,
    input  logic       rd_rst,
    output logic [7:0] core_data_o,
    output logic       core_en_o,
    output logic       core_er_o,
    output logic       overflow_o,
    output logic       underflow_o
);

    localparam int PTR_W = ADDR_W + 1;

    gword_t              in_word;
    gword_t              head_word;
    gword_t              out_word;
    logic                wr_we;
    logic [ADDR_W-1:0]   wr_addr;
    logic [ADDR_W-1:0]   rd_addr;
    logic [PTR_W-1:0]    wgray;
    logic [PTR_W-1:0]    rgray;
    logic [PTR_W-1:0]    wsync_bin;
    logic [PTR_W-1:0]    rsync_bin;
    logic                wr_full;
    logic                wr_drop;
    logic                rd_priming;
    logic                rd_insert;

    assign in_word.data = gtx_data_i;
    assign in_word.en   = gtx_en_i;
    assign in_word.er   = gtx_er_i;

    geb_ptr_sync #(.W(PTR_W)) u_rptr_to_wr (
        .clk    (wr_clk),
        .rst    (wr_rst),
        .gray_i (rgray),
        .bin_o  (rsync_bin)
    );

    geb_ptr_sync #(.W(PTR_W)) u_wptr_to_rd (
        .clk    (rd_clk),
        .rst    (rd_rst),
        .gray_i (wgray),
        .bin_o  (wsync_bin)
    );

    geb_wr_ctl #(.AW(ADDR_W), .DEL_ABOVE(DELETE_ABOVE)) u_wr (
        .clk         (wr_clk),
        .rst         (wr_rst),
        .in_idle_i   (gw_is_idle(in_word)),
        .rsync_bin_i (rsync_bin),
        .we_o        (wr_we),
        .waddr_o     (wr_addr),
        .wgray_o     (wgray),
        .full_o      (wr_full),
        .drop_o      (wr_drop),
        .overflow_o  (overflow_o)
    );

    geb_store #(.AW(ADDR_W)) u_store (
        .wr_clk (wr_clk),
        .we     (wr_we),
        .waddr  (wr_addr),
        .wdata  (in_word),
        .raddr  (rd_addr),
        .rdata  (head_word)
    );

    geb_rd_ctl #(.AW(ADDR_W), .START_AT(TARGET_FILL), .INS_BELOW(INSERT_BELOW)) u_rd (
        .clk         (rd_clk),
        .rst         (rd_rst),
        .wsync_bin_i (wsync_bin),
        .rdata_i     (head_word),
        .raddr_o     (rd_addr),
        .rgray_o     (rgray),
        .word_o      (out_word),
        .underflow_o (underflow_o),
        .priming_o   (rd_priming),
        .insert_o    (rd_insert)
    );

    assign core_data_o = out_word.data;
    assign core_en_o   = out_word.en;
    assign core_er_o   = out_word.er;

endmodule

// File: rtl/geb_checker.sv
module geb_checker #(
    parameter int PW = 6
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          gtx_en_i,
    input logic          gtx_er_i,
    input logic [7:0]    core_data_o,
    input logic          core_en_o,
    input logic          core_er_o,
    input logic          overflow_o,
    input logic          underflow_o,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rgray,
    input logic          wr_full,
    input logic          wr_drop,
    input logic          rd_priming,
    input logic          rd_insert
);

    AST_OVF_CLEARED_BY_RESET: assert property (@(posedge wr_clk)
        wr_rst |=> !overflow_o); // R9

    AST_UDF_CLEARED_BY_RESET: assert property (@(posedge rd_clk)
        rd_rst |=> (!underflow_o && !core_en_o && !core_er_o)); // R9

    AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (wr_rst)
        overflow_o |=> overflow_o); // R7

    AST_UDF_STICKY: assert property (@(posedge rd_clk) disable iff (rd_rst)
        underflow_o |=> underflow_o); // R8

    AST_WGRAY_ONE_BIT: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wgray ^ $past(wgray)) <= 1); // R10

    AST_RGRAY_ONE_BIT: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rgray ^ $past(rgray)) <= 1); // R10

    AST_FRAME_WORD_STORED: assert property (@(posedge wr_clk) disable iff (wr_rst)
        ((gtx_en_i || gtx_er_i) && !wr_full) |=> (wgray != $past(wgray))); // R2

    AST_DROP_HOLDS_WPTR: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_drop |=> $stable(wgray)); // R3

    AST_INSERT_ZERO_WORD: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_insert |=> (core_data_o == 8'h00 && !core_en_o && !core_er_o)); // R4

    AST_PRIME_IDLE_OUT: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_priming |=> (!core_en_o && !core_er_o)); // R6

endmodule

bind gmii_tx_elastic geb_checker #(.PW(PTR_W)) u_geb_chk (
    .wr_clk      (wr_clk),
    .wr_rst      (wr_rst),
    .rd_clk      (rd_clk),
    .rd_rst      (rd_rst),
    .gtx_en_i    (gtx_en_i),
    .gtx_er_i    (gtx_er_i),
    .core_data_o (core_data_o),
    .core_en_o   (core_en_o),
    .core_er_o   (core_er_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o),
    .wgray       (wgray),
    .rgray       (rgray),
    .wr_full     (wr_full),
    .wr_drop     (wr_drop),
    .rd_priming  (rd_priming),
    .rd_insert   (rd_insert)
);

// File: tb/tb_gmii_tx_elastic.sv
module tb_gmii_tx_elastic;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_rst = 1'b1;
    logic       rd_rst = 1'b1;
    logic [7:0] gtx_data_i = 8'h00;
    logic       gtx_en_i = 1'b0;
    logic       gtx_er_i = 1'b0;
    logic [7:0] core_data_o;
    logic       core_en_o;
    logic       core_er_o;
    logic       overflow_o;
    logic       underflow_o;

    logic wr_run = 1'b1;
    logic rd_run = 1'b1;
    int   wr_every = 0;
    int   rd_every = 0;

    int n_chk = 0;
    int n_fail = 0;

    gmii_tx_elastic dut (
        .wr_clk      (wr_clk),
        .wr_rst      (wr_rst),
        .gtx_data_i  (gtx_data_i),
        .gtx_en_i    (gtx_en_i),
        .gtx_er_i    (gtx_er_i),
        .rd_clk      (rd_clk),
        .rd_rst      (rd_rst),
        .core_data_o (core_data_o),
        .core_en_o   (core_en_o),
        .core_er_o   (core_er_o),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o)
    );

    // 125 MHz clocks, each can be held to stretch its domain.
    initial begin
        forever begin
            #4;
            if (wr_run) wr_clk = ~wr_clk;
        end
    end

    initial begin
        #1;
        forever begin
            #4;
            if (rd_run) rd_clk = ~rd_clk;
        end
    end

    // Periodic stretching: one lost cycle every N cycles.
    int wcnt = 0;
    always @(posedge wr_clk) begin
        if (wr_every != 0) begin
            wcnt = wcnt + 1;
            if (wcnt >= wr_every) begin
                wcnt = 0;
                wr_run = 1'b0;
                #8;
                wr_run = 1'b1;
            end
        end
    end

    int rcnt = 0;
    always @(posedge rd_clk) begin
        if (rd_every != 0) begin
            rcnt = rcnt + 1;
            if (rcnt >= rd_every) begin
                rcnt = 0;
                rd_run = 1'b0;
                #8;
                rd_run = 1'b1;
            end
        end
    end

    // Output monitor
    logic [8:0] rx_words[$];
    int         rx_lens[$];
    int         cur_len = 0;
    int         rd_cycles = 0;
    int         first_data = -1;
    int         ext_cnt = 0;
    int         zero_cnt = 0;

    always @(negedge rd_clk) begin
        if (!rd_rst) begin
            rd_cycles = rd_cycles + 1;
            if (core_en_o) begin
                if (first_data < 0) first_data = rd_cycles;
                rx_words.push_back({core_data_o, core_er_o});
                cur_len = cur_len + 1;
            end else begin
                if (cur_len > 0) rx_lens.push_back(cur_len);
                cur_len = 0;
                if (core_er_o) ext_cnt = ext_cnt + 1;
                if (!core_er_o && core_data_o == 8'h00) zero_cnt = zero_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic en, input logic er);
        @(negedge wr_clk);
        gtx_data_i = d;
        gtx_en_i   = en;
        gtx_er_i   = er;
    endtask

    task automatic do_reset();
        wr_every = 0;
        rd_every = 0;
        wr_run = 1'b1;
        rd_run = 1'b1;
        gtx_data_i = 8'h00;
        gtx_en_i = 1'b0;
        gtx_er_i = 1'b0;
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        repeat (5) @(negedge rd_clk);
        chk("R9 data", core_data_o, 0);
        chk("R9 qualifiers", {core_en_o, core_er_o}, 0);
        chk("R9 flags", {overflow_o, underflow_o}, 0);
        rx_words.delete();
        rx_lens.delete();
        cur_len = 0;
        rd_cycles = 0;
        first_data = -1;
        ext_cnt = 0;
        zero_cnt = 0;
        wr_rst = 1'b0;
        rd_rst = 1'b0;
    endtask

    // Frame table: length, first byte, byte step, error index (FFFF none),
    // leading gap, write stretch period, read stretch period.
    typedef struct packed {
        logic [15:0] len;
        logic [7:0]  first;
        logic [7:0]  step;
        logic [15:0] err_at;
        logic [7:0]  gap;
        logic [7:0]  wr_per;
        logic [7:0]  rd_per;
    } fvec_t;

    localparam int NVEC = 6;
    localparam fvec_t VECS [NVEC] = '{
        '{16'd64,  8'h10, 8'd1,  16'hFFFF, 8'd0,  8'd0,  8'd0},
        '{16'd20,  8'hA0, 8'd3,  16'd5,    8'd8,  8'd0,  8'd0},
        '{16'd100, 8'h01, 8'd7,  16'hFFFF, 8'd12, 8'd12, 8'd0},
        '{16'd80,  8'hC3, 8'd5,  16'd50,   8'd12, 8'd0,  8'd10},
        '{16'd8,   8'hFF, 8'd1,  16'hFFFF, 8'd12, 8'd5,  8'd0},
        '{16'd120, 8'h33, 8'd11, 16'hFFFF, 8'd20, 8'd0,  8'd15}
    };

    initial begin
        #(8 * 150000);
        n_chk = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();

        // Table walk: frames under differing clock stretch patterns.
        for (int v = 0; v < NVEC; v++) begin
            wr_every = int'(VECS[v].wr_per);
            rd_every = int'(VECS[v].rd_per);
            for (int g = 0; g < int'(VECS[v].gap); g++) send(8'h55, 1'b0, 1'b0);
            for (int i = 0; i < int'(VECS[v].len); i++) begin
                send(VECS[v].first + 8'(i * int'(VECS[v].step)), 1'b1,
                     (16'(i) == VECS[v].err_at));
            end
            wr_every = 0;
            rd_every = 0;
        end
        for (int g = 0; g < 60; g++) send(8'h55, 1'b0, 1'b0);

        // R6: the first frame was written straight after reset; output idles
        // until the fill reaches the target, plus the crossing delay.
        chk("R6 priming delay", int'(first_data >= 17), 1);
        chk("R5 frame count", rx_lens.size(), NVEC);
        begin
            int pos = 0;
            for (int v = 0; v < NVEC; v++) begin
                int bad = 0;
                if (v < rx_lens.size())
                    chk("R5 frame length", rx_lens[v], int'(VECS[v].len));
                for (int i = 0; i < int'(VECS[v].len); i++) begin
                    logic [8:0] expw;
                    expw = {VECS[v].first + 8'(i * int'(VECS[v].step)),
                            (16'(i) == VECS[v].err_at)};
                    if (pos >= rx_words.size() || rx_words[pos] != expw) bad = bad + 1;
                    pos = pos + 1;
                end
                chk("R1/R10 frame content mismatches", bad, 0);
            end
        end

        // R3 and R2: reader stalled, idles keep arriving, plus
        // error-only words that must survive.
        rd_run = 1'b0;
        for (int g = 0; g < 60; g++) begin
            if (g % 12 == 6) send(8'h0F, 1'b0, 1'b1);
            else send(8'h55, 1'b0, 1'b0);
        end
        chk("R3 no overflow while idles discarded", overflow_o, 0);
        rd_run = 1'b1;
        for (int g = 0; g < 60; g++) send(8'h55, 1'b0, 1'b0);
        chk("R2 error-only words delivered", ext_cnt, 5);

        // R4: writer stalled in a gap, reader must insert zero idles.
        zero_cnt = 0;
        wr_run = 1'b0;
        repeat (100) @(negedge rd_clk);
        chk("R4 no underflow while inserting", underflow_o, 0);
        chk("R4 inserted zero idles", int'(zero_cnt >= 80), 1);
        chk("R4 output during stall", {core_data_o, core_en_o, core_er_o}, 0);
        wr_run = 1'b1;
        for (int g = 0; g < 30; g++) send(8'h55, 1'b0, 1'b0);

        // R7: reader stalled during a long frame.
        rd_run = 1'b0;
        for (int i = 0; i < 40; i++) send(8'(i), 1'b1, 1'b0);
        chk("R7 overflow set", overflow_o, 1);
        rd_run = 1'b1;
        for (int g = 0; g < 30; g++) send(8'h55, 1'b0, 1'b0);
        chk("R7 overflow sticky", overflow_o, 1);
        do_reset();
        chk("R7 overflow cleared by reset", overflow_o, 0);

        // R8: writer stalled in the middle of a frame.
        for (int g = 0; g < 40; g++) send(8'h55, 1'b0, 1'b0);
        for (int i = 0; i < 25; i++) send(8'h80 + 8'(i), 1'b1, 1'b0);
        chk("R8 no underflow before stall", underflow_o, 0);
        wr_run = 1'b0;
        repeat (60) @(negedge rd_clk);
        chk("R8 underflow set", underflow_o, 1);
        chk("R8 idle out when empty", {core_data_o, core_en_o, core_er_o}, 0);
        repeat (5) @(negedge rd_clk);
        chk("R8 underflow sticky", underflow_o, 1);
        wr_run = 1'b1;
        do_reset();
        chk("R8 underflow cleared by reset", underflow_o, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule